// File: doc/BRIEF.md
# SPI Status Flag and Request Controller

This block gathers the condition signals of an SPI peripheral with transmit and receive FIFOs and turns them into software-visible status, one interrupt line and two DMA request lines. The shift engine supplies single-cycle event pulses: word done, frame done, transfer done, transmit underrun, receive overrun and data match. It also supplies a busy level. The FIFOs supply their current occupancy counts. Events are latched into sticky flags. Software clears each sticky flag on its own by writing a 1 to that flag's bit.

Two further flags are not latched. The transmit data request follows the transmit FIFO level against a programmable watermark, and so does the receive data ready flag against its own watermark. The enables select which flags raise the interrupt. A separate DMA enable pair drives the FIFO service requests. When the interrupt enable of a FIFO flag is set, that flag is handed to the CPU, and its DMA request is held off.

Access uses a word-wide register port. Writes take effect on the next clock edge. Reads return data in the same cycle from the address presented.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset, the interrupt enables, DMA enables, watermarks and sticky flags are all zero, and the interrupt and both DMA requests are low.
- R2: An event pulse sets its sticky flag at the next clock edge. The flag then stays set after the pulse ends. Status word bits: 2 word done, 3 frame done, 4 transfer done, 5 underrun, 6 overrun, 7 data match.
- R3: A write to the status word (offset 0) clears each sticky flag whose bit is 1 and leaves flags whose bit is 0 unchanged. If an event arrives in the same cycle as its clear, the flag stays set.
- R4: Status bit 0 (transmit request) is 1 one cycle after the transmit FIFO count is at or below the transmit watermark, and 0 when the count is above it.
- R5: Status bit 1 (receive ready) is 1 one cycle after the receive FIFO count is strictly above the receive watermark, and 0 otherwise.
- R6: Writing 1 to status bits 0, 1 or 8 has no effect on them.
- R7: Status bit 8 reflects the busy input one cycle later, and no interrupt enable exists for it.
- R8: The interrupt enable word (offset 1, bits 0 to 7 matching status bits 0 to 7) is read/write, and bit 8 and above read as 0. The interrupt output is high exactly when some enabled status bit is set.
- R9: DMA enable word offset 2: bit 0 transmit, bit 1 receive. The transmit DMA request is high when transmit DMA is enabled, the transmit request flag is set and interrupt enable bit 0 is clear. The receive request follows the same rule with bit 1.
- R10: The watermark word (offset 3) holds the transmit watermark at bit 0 and the receive watermark at bit 16. Each field keeps only the low log2(depth) bits of the written value.
- R11: Offset 4 returns the live transmit FIFO count at bit 0 and the receive count at bit 16. Offset 5 returns log2 of the transmit depth in bits 7:0 and log2 of the receive depth in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | AW | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| tx_level | input | FIFO_LOG2+1 | Transmit FIFO occupancy |
| rx_level | input | FIFO_LOG2+1 | Receive FIFO occupancy |
| ev_word | input | 1 | Word done pulse |
| ev_frame | input | 1 | Frame done pulse |
| ev_xfer | input | 1 | Transfer done pulse |
| ev_under | input | 1 | Transmit underrun pulse |
| ev_over | input | 1 | Receive overrun pulse |
| ev_match | input | 1 | Data match pulse |
| eng_busy | input | 1 | Shift engine busy level |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Two functions can act on one flag in the same cycle: an event pulse setting it and a software write clearing it. The bench drives the overrun pulse and a clear of the overrun bit in the same cycle, then reads the status word and expects the flag to be set. It also clears a separate flag while leaving its neighbours alone, to show that the clear affects only the bits written as 1.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    // status word bit positions
    localparam int ST_TXREQ   = 0;
    localparam int ST_RXRDY   = 1;
    localparam int ST_WORD    = 2;
    localparam int ST_BUSY    = 8;
    localparam int ST_WIDTH   = 9;
    localparam int NUM_STICKY = 6;
    localparam int NUM_IRQ    = 8;

    // register word offsets
    localparam int REG_STATUS = 0;
    localparam int REG_IRQEN  = 1;
    localparam int REG_DMAEN  = 2;
    localparam int REG_WATER  = 3;
    localparam int REG_LEVEL  = 4;
    localparam int REG_PARAM  = 5;

    // field placement inside words
    localparam int RX_FIELD_LSB = 16;
    localparam int PARAM_RX_LSB = 8;
    localparam int DMA_TX       = 0;
    localparam int DMA_RX       = 1;
endpackage

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a new event outranks a clear in the same cycle
            st_d.flag[i] = set_i[i] | (st_q.flag[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);
        // R3
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
        // R3
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g]) |=> (flag_o[g] == $past(flag_o[g])));
    end
endmodule

// File: rtl/spi_level_req.sv
module spi_level_req #(
    parameter int LW = 2,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_level,
    input  logic [LW-1:0] tx_wm,
    input  logic [LW-1:0] rx_wm,
    input  logic          busy_i,
    output logic          tx_req_o,
    output logic          rx_rdy_o,
    output logic          busy_o
);
    typedef struct packed {
        logic tx_req;
        logic rx_rdy;
        logic busy;
    } lvl_t;

    lvl_t lv_d, lv_q;

    always_comb begin
        lv_d        = lv_q;
        lv_d.tx_req = (tx_level <= CW'(tx_wm));
        lv_d.rx_rdy = (rx_level >  CW'(rx_wm));
        lv_d.busy   = busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    assign tx_req_o = lv_q.tx_req;
    assign rx_rdy_o = lv_q.rx_rdy;
    assign busy_o   = lv_q.busy;

    // R4
    empty_tx_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |=> tx_req_o);
    // R4
    above_wm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level > CW'(tx_wm)) |=> !tx_req_o);
    // R5
    empty_rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> !rx_rdy_o);
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route #(
    parameter int NI = 8
) (
    input  logic [NI-1:0] flags_i,
    input  logic [NI-1:0] en_i,
    input  logic          tx_req_i,
    input  logic          rx_rdy_i,
    input  logic [1:0]    dma_en_i,
    output logic          irq_o,
    output logic          tx_dma_o,
    output logic          rx_dma_o
);
    import spi_flag_pkg::*;

    always_comb begin
        irq_o    = |(flags_i & en_i);
        // FIFO interrupt enable takes the request away from DMA
        tx_dma_o = dma_en_i[DMA_TX] & tx_req_i & ~en_i[ST_TXREQ];
        rx_dma_o = dma_en_i[DMA_RX] & rx_rdy_i & ~en_i[ST_RXRDY];
    end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl #(
    parameter int FIFO_LOG2 = 2,
    parameter int AW        = 3,
    parameter int DW        = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_wr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [FIFO_LOG2:0]   tx_level,
    input  logic [FIFO_LOG2:0]   rx_level,
    input  logic                 ev_word,
    input  logic                 ev_frame,
    input  logic                 ev_xfer,
    input  logic                 ev_under,
    input  logic                 ev_over,
    input  logic                 ev_match,
    input  logic                 eng_busy,
    output logic                 irq,
    output logic                 tx_dma_req,
    output logic                 rx_dma_req
);
    import spi_flag_pkg::*;

    localparam int LW = FIFO_LOG2;
    localparam int CW = FIFO_LOG2 + 1;

    typedef struct packed {
        logic [NUM_IRQ-1:0] ie;
        logic [1:0]         dma;
        logic [LW-1:0]      txwm;
        logic [LW-1:0]      rxwm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [NUM_STICKY-1:0] w1c_clr;
    logic [NUM_STICKY-1:0] ev_vec;
    logic [NUM_STICKY-1:0] sticky;
    logic                  tx_req, rx_rdy, busy_q;
    logic [ST_WIDTH-1:0]   status;

    assign ev_vec = {ev_match, ev_over, ev_under, ev_xfer, ev_frame, ev_word};

    always_comb begin
        cfg_d   = cfg_q;
        w1c_clr = '0;
        if (reg_wr) begin
            case (reg_addr)
                AW'(REG_STATUS): w1c_clr   = reg_wdata[ST_WORD +: NUM_STICKY];
                AW'(REG_IRQEN):  cfg_d.ie  = reg_wdata[NUM_IRQ-1:0];
                AW'(REG_DMAEN):  cfg_d.dma = reg_wdata[1:0];
                AW'(REG_WATER): begin
                    cfg_d.txwm = reg_wdata[0 +: LW];
                    cfg_d.rxwm = reg_wdata[RX_FIELD_LSB +: LW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    spi_flag_bank #(.N(NUM_STICKY)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_vec),
        .clr_i  (w1c_clr),
        .flag_o (sticky)
    );

    spi_level_req #(.LW(LW), .CW(CW)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_wm    (cfg_q.txwm),
        .rx_wm    (cfg_q.rxwm),
        .busy_i   (eng_busy),
        .tx_req_o (tx_req),
        .rx_rdy_o (rx_rdy),
        .busy_o   (busy_q)
    );

    assign status = {busy_q, sticky, rx_rdy, tx_req};

    spi_req_route #(.NI(NUM_IRQ)) u_route (
        .flags_i  (status[NUM_IRQ-1:0]),
        .en_i     (cfg_q.ie),
        .tx_req_i (tx_req),
        .rx_rdy_i (rx_rdy),
        .dma_en_i (cfg_q.dma),
        .irq_o    (irq),
        .tx_dma_o (tx_dma_req),
        .rx_dma_o (rx_dma_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(REG_STATUS): reg_rdata[ST_WIDTH-1:0] = status;
            AW'(REG_IRQEN):  reg_rdata[NUM_IRQ-1:0]  = cfg_q.ie;
            AW'(REG_DMAEN):  reg_rdata[1:0]          = cfg_q.dma;
            AW'(REG_WATER): begin
                reg_rdata[0 +: LW]            = cfg_q.txwm;
                reg_rdata[RX_FIELD_LSB +: LW] = cfg_q.rxwm;
            end
            AW'(REG_LEVEL): begin
                reg_rdata[0 +: CW]            = tx_level;
                reg_rdata[RX_FIELD_LSB +: CW] = rx_level;
            end
            AW'(REG_PARAM): begin
                reg_rdata[7:0]                = 8'(FIFO_LOG2);
                reg_rdata[PARAM_RX_LSB +: 8]  = 8'(FIFO_LOG2);
            end
            default: ;
        endcase
    end

    // R9
    tx_dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ie[ST_TXREQ] |-> !tx_dma_req);
    // R9
    rx_dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.ie[ST_RXRDY] |-> !rx_dma_req);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ie == '0) |-> !irq);
    // R7
    busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> status[ST_BUSY]);
endmodule

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 3;
    localparam int DW = 32;
    localparam int FL = 2;

    localparam int A_STATUS = 0;
    localparam int A_IRQEN  = 1;
    localparam int A_DMAEN  = 2;
    localparam int A_WATER  = 3;
    localparam int A_LEVEL  = 4;
    localparam int A_PARAM  = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic [FL:0]   tx_level, rx_level;
    logic          ev_word, ev_frame, ev_xfer, ev_under, ev_over, ev_match, eng_busy;
    logic          irq, tx_dma_req, rx_dma_req;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    spi_flag_ctrl #(.FIFO_LOG2(FL), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .ev_word(ev_word), .ev_frame(ev_frame), .ev_xfer(ev_xfer),
        .ev_under(ev_under), .ev_over(ev_over), .ev_match(ev_match),
        .eng_busy(eng_busy), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        cyc();
        reg_wr    = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        tx_level = '0; rx_level = '0;
        ev_word = 0; ev_frame = 0; ev_xfer = 0; ev_under = 0; ev_over = 0; ev_match = 0;
        eng_busy = 0;
        cyc(); cyc();
        rd(A_STATUS, v); check("R1 status in reset", v, 32'h0);
        check("R1 irq in reset", 32'(irq), 32'h0);
        check("R1 dma in reset", {30'h0, tx_dma_req, rx_dma_req}, 32'h0);
        rst_n = 1'b1;
        cyc(); cyc();
        rd(A_IRQEN, v); check("R1 irq enables", v, 32'h0);
        rd(A_DMAEN, v); check("R1 dma enables", v, 32'h0);
        rd(A_WATER, v); check("R1 watermarks", v, 32'h0);
        rd(A_STATUS, v); check("R4 empty fifo requests", v, 32'h001);
    endtask

    task automatic t_sticky();
        ev_word = 1; cyc(); ev_word = 0;
        rd(A_STATUS, v); check("R2 word flag set", v, 32'h005);
        cyc(); cyc(); cyc();
        rd(A_STATUS, v); check("R2 word flag held", v, 32'h005);
        ev_frame = 1; ev_match = 1; cyc(); ev_frame = 0; ev_match = 0;
        rd(A_STATUS, v); check("R2 frame and match set", v, 32'h08D);
        ev_xfer = 1; ev_under = 1; cyc(); ev_xfer = 0; ev_under = 0;
        rd(A_STATUS, v); check("R2 xfer and underrun set", v, 32'h0BD);
    endtask

    task automatic t_w1c();
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, v); check("R3 zero write keeps flags", v, 32'h0BD);
        wr(A_STATUS, 32'h008);
        rd(A_STATUS, v); check("R3 clear frame only", v, 32'h0B5);
        reg_addr = AW'(A_STATUS); reg_wdata = 32'h040; reg_wr = 1'b1; ev_over = 1;
        cyc();
        reg_wr = 1'b0; ev_over = 0;
        rd(A_STATUS, v); check("R3 set wins over clear", v, 32'h0F5);
        wr(A_STATUS, 32'h0FC);
        rd(A_STATUS, v); check("R3 clear all sticky", v, 32'h001);
    endtask

    task automatic t_level_ro();
        wr(A_STATUS, 32'h103);
        rd(A_STATUS, v); check("R6 level bits ignore write", v, 32'h001);
        eng_busy = 1; cyc();
        rd(A_STATUS, v); check("R7 busy follows input", v, 32'h101);
        wr(A_STATUS, 32'h100);
        rd(A_STATUS, v); check("R6 busy ignores write", v, 32'h101);
        eng_busy = 0; cyc();
        rd(A_STATUS, v); check("R7 busy drops", v, 32'h001);
    endtask

    task automatic t_tx_req();
        wr(A_WATER, 32'h2);
        tx_level = 3'd2; cyc();
        rd(A_STATUS, v); check("R4 level equal watermark", v & 32'h1, 32'h1);
        tx_level = 3'd3; cyc();
        rd(A_STATUS, v); check("R4 level above watermark", v & 32'h1, 32'h0);
        tx_level = 3'd4; cyc();
        rd(A_STATUS, v); check("R4 full fifo", v & 32'h1, 32'h0);
        tx_level = 3'd0; cyc();
        rd(A_STATUS, v); check("R4 drained fifo", v & 32'h1, 32'h1);
    endtask

    task automatic t_rx_rdy();
        wr(A_WATER, 32'h0001_0000);
        rx_level = 3'd1; cyc();
        rd(A_STATUS, v); check("R5 level equal watermark", v & 32'h2, 32'h0);
        rx_level = 3'd2; cyc();
        rd(A_STATUS, v); check("R5 level above watermark", v & 32'h2, 32'h2);
        rx_level = 3'd0; cyc();
        rd(A_STATUS, v); check("R5 empty fifo", v & 32'h2, 32'h0);
    endtask

    task automatic t_wm_trunc();
        wr(A_WATER, 32'h0005_0007);
        rd(A_WATER, v); check("R10 truncated watermarks", v, 32'h0001_0003);
        tx_level = 3'd3; cyc();
        rd(A_STATUS, v); check("R10 truncated tx watermark used", v & 32'h1, 32'h1);
        tx_level = 3'd0;
        wr(A_WATER, 32'h0);
    endtask

    task automatic t_irq();
        wr(A_IRQEN, 32'h1FF);
        rd(A_IRQEN, v); check("R8 enable readback", v, 32'h0FF);
        check("R8 irq from tx request", 32'(irq), 32'h1);
        wr(A_IRQEN, 32'h004);
        check("R8 enabled flag clear", 32'(irq), 32'h0);
        ev_word = 1; cyc(); ev_word = 0;
        check("R8 irq on word done", 32'(irq), 32'h1);
        wr(A_STATUS, 32'h004);
        check("R8 irq after clear", 32'(irq), 32'h0);
        wr(A_IRQEN, 32'h040);
        ev_under = 1; cyc(); ev_under = 0;
        check("R8 disabled flag no irq", 32'(irq), 32'h0);
        wr(A_STATUS, 32'h0FC);
        wr(A_IRQEN, 32'h0);
    endtask

    task automatic t_dma();
        wr(A_DMAEN, 32'h3);
        check("R9 tx dma requested", 32'(tx_dma_req), 32'h1);
        check("R9 rx dma idle", 32'(rx_dma_req), 32'h0);
        rx_level = 3'd1; cyc();
        check("R9 rx dma requested", 32'(rx_dma_req), 32'h1);
        wr(A_IRQEN, 32'h1);
        check("R9 tx dma masked by irq enable", {30'h0, tx_dma_req, rx_dma_req}, 32'h1);
        wr(A_IRQEN, 32'h2);
        check("R9 rx dma masked by irq enable", {30'h0, tx_dma_req, rx_dma_req}, 32'h2);
        wr(A_IRQEN, 32'h0);
        wr(A_DMAEN, 32'h1);
        check("R9 rx dma disabled", {30'h0, tx_dma_req, rx_dma_req}, 32'h2);
        rx_level = 3'd0;
        wr(A_DMAEN, 32'h0);
        check("R9 both dma disabled", {30'h0, tx_dma_req, rx_dma_req}, 32'h0);
    endtask

    task automatic t_info();
        tx_level = 3'd3; rx_level = 3'd2;
        rd(A_LEVEL, v); check("R11 fifo counts", v, 32'h0002_0003);
        rd(A_PARAM, v); check("R11 depth exponents", v, 32'h0000_0202);
        tx_level = 3'd0; rx_level = 3'd0;
    endtask

    initial begin
        t_reset();
        t_sticky();
        t_w1c();
        t_level_ro();
        t_tx_req();
        t_rx_rdy();
        t_wm_trunc();
        t_irq();
        t_dma();
        t_info();
        report();
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule